// File: doc/BRIEF.md
# Banked GPIO Controller with Edge Capture

This block is a register-mapped general-purpose pin controller. Its pins are grouped in banks of 32, and the pin count is a parameter (64 or 96). Each pin carries an output latch, a direction bit, a rising-edge enable, a falling-edge enable, a sticky edge-status bit and a 2-bit alternate-function code. The controller samples the pin inputs through a two-stage synchroniser and drives the pin outputs and output enables. Any enabled edge it detects raises a single interrupt line.

Software reaches every control through a simple single-cycle register bus. A write takes effect at the clock edge on which `bus_sel` and `bus_wr` are high. Read data is combinational from the address while `bus_sel` is high and `bus_wr` is low. The output latch has separate set and clear words, so one pin can change without a read-modify-write. The edge status is cleared by writing ones to it.

Top module: `gpb_ctrl`

## Requirements
- R1: With NB = NPINS/32 banks, the register word of kind k for bank b sits at byte address k×NB×4 + b×4. The kinds are numbered in this order: level 0, direction 1, set 2, clear 3, rising-enable 4, falling-enable 5, edge-status 6, alternate-function 7. Address bits [1:0] are ignored.
- R2: A level word returns the synchronised pin inputs, with pin p at bit p%32. An input change becomes visible two clock edges after it is sampled. Writes to level words are ignored.
- R3: Writing a set word raises the output latch for each 1 bit. The 0 bits leave the latch as it was. `pin_out` shows the result after the write edge.
- R4: Writing a clear word lowers the output latch for each 1 bit. The 0 bits leave the latch as it was.
- R5: A direction bit of 1 makes the pin an output, and `pin_oe` for that pin is then 1. A direction bit of 0 makes the pin an input. Direction, enable and alternate-function words read back what was written.
- R6: A synchronised 0-to-1 transition on a pin whose rising-enable bit is 1 sets that pin's edge-status bit.
- R7: A synchronised 1-to-0 transition on a pin whose falling-enable bit is 1 sets that pin's edge-status bit. Both enables may be set together.
- R8: Writing 1 to an edge-status bit clears only that bit. If an edge is detected in the same cycle as that clear, the bit stays set.
- R9: Each pin has a 2-bit alternate-function code at bits (p%16)×2 of alternate-function word p/16. The alternate-function words start at address 7×NB×4. The codes appear on `alt_sel[2p+1:2p]`, and code 0 means plain GPIO.
- R10: `irq` is the OR of all edge-status bits in all banks. It stays high until every pending bit is cleared.
- R11: After reset, the output latch and the direction, enable, edge-status and alternate-function registers are all zero.
- R12: Reads from addresses beyond the last alternate-function word return zero, and writes to them change nothing. Set and clear words read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| pin_in | input | NPINS | Pin input levels |
| pin_out | output | NPINS | Output latch |
| pin_oe | output | NPINS | Output enable per pin |
| alt_sel | output | 2×NPINS | Alternate-function codes |
| irq | output | 1 | Combined edge interrupt |

## Verification
The bench builds the controller with 96 pins, so three banks are present and the address map uses a stride of 12 bytes per register kind. This brings the third bank's edge logic and the last pin (95) within reach. It also reaches the top alternate-function word at offset 104 and the first unmapped address, 108. At that parameter value, a decoder that assumed two banks would misplace every register kind above the level words.

// File: rtl/gpb_pkg.sv
// Shared definitions for the banked GPIO controller.
// Assumes banks are exactly 32 pins wide.
package gpb_pkg;
    localparam int BANK_W = 32;

    // Register kinds; the numeric order sets the address map.
    typedef enum logic [2:0] {
        REG_LVL = 3'd0,
        REG_DIR = 3'd1,
        REG_SET = 3'd2,
        REG_CLR = 3'd3,
        REG_REN = 3'd4,
        REG_FEN = 3'd5,
        REG_STS = 3'd6,
        REG_ALT = 3'd7
    } reg_kind_e;
endpackage

// File: rtl/gpb_pin_bank.sv
// One 32-pin bank: input synchroniser, edge capture, output latch,
// direction and edge-enable registers.
// Assumes at most one write strobe is active per cycle (distinct addresses).
module gpb_pin_bank #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_in,
    input  logic         we_dir,
    input  logic         we_set,
    input  logic         we_clr,
    input  logic         we_ren,
    input  logic         we_fen,
    input  logic         we_sts,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] level,
    output logic [W-1:0] dir,
    output logic [W-1:0] dout,
    output logic [W-1:0] ren,
    output logic [W-1:0] fen,
    output logic [W-1:0] sts
);
    logic [W-1:0] sync1, sync2, prev;
    logic [W-1:0] rise_hit, fall_hit, clr_mask;

    // Two-flop synchroniser plus one-cycle history for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync1 <= '0;
            sync2 <= '0;
            prev  <= '0;
        end else begin
            sync1 <= pin_in;
            sync2 <= sync1;
            prev  <= sync2;
        end
    end

    assign level    = sync2;
    assign rise_hit = sync2 & ~prev & ren;
    assign fall_hit = ~sync2 & prev & fen;
    assign clr_mask = we_sts ? wdata : '0;

    // Direction and edge-enable registers, written whole.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir <= '0;
            ren <= '0;
            fen <= '0;
        end else begin
            if (we_dir) dir <= wdata;
            if (we_ren) ren <= wdata;
            if (we_fen) fen <= wdata;
        end
    end

    // Output latch updated by the set and clear strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout <= '0;
        end else if (we_set) begin
            dout <= dout | wdata;
        end else if (we_clr) begin
            dout <= dout & ~wdata;
        end
    end

    // Sticky edge status; a new edge wins over a clear of the same bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sts <= '0;
        end else begin
            sts <= (sts & ~clr_mask) | rise_hit | fall_hit;
        end
    end

    AST_EDGE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (|(rise_hit | fall_hit)) |=> ((sts & $past(rise_hit | fall_hit)) == $past(rise_hit | fall_hit))); // R8
    AST_STS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!we_sts && !(|(rise_hit | fall_hit))) |=> $stable(sts)); // R6
    AST_SET_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        we_set |=> ((dout & $past(wdata)) == $past(wdata))); // R3
    AST_CLR_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (we_clr && !we_set) |=> ((dout & $past(wdata)) == '0)); // R4
endmodule

// File: rtl/gpb_alt_store.sv
// Storage for packed 2-bit alternate-function codes, 16 pins per word.
// Assumes the decoder raises at most one word strobe per cycle.
module gpb_alt_store #(
    parameter int NW = 4,
    parameter int W  = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NW-1:0]   we,
    input  logic [W-1:0]    wdata,
    output logic [NW*W-1:0] codes
);
    for (genvar i = 0; i < NW; i++) begin : g_word
        // One code word, loaded whole on its strobe.
        always_ff @(posedge clk) begin
            if (!rst_n) codes[i*W +: W] <= '0;
            else if (we[i]) codes[i*W +: W] <= wdata;
        end
    end

    AST_ALT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !(|we) |=> $stable(codes)); // R9
endmodule

// File: rtl/gpb_ctrl.sv
// Banked GPIO controller top: address decode, read mux, bank instances,
// alternate-function store and the combined interrupt.
// Assumes NPINS is a multiple of 32 and ADDR_W covers 9*NB words.
module gpb_ctrl
    import gpb_pkg::*;
#(
    parameter int NPINS  = 64,
    parameter int ADDR_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_sel,
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [31:0]         bus_wdata,
    output logic [31:0]         bus_rdata,
    input  logic [NPINS-1:0]    pin_in,
    output logic [NPINS-1:0]    pin_out,
    output logic [NPINS-1:0]    pin_oe,
    output logic [2*NPINS-1:0]  alt_sel,
    output logic                irq
);
    localparam int NB   = NPINS / BANK_W;
    localparam int NALT = 2 * NB;
    localparam int ALT0 = int'(REG_ALT) * NB;
    localparam int LAST = ALT0 + NALT;

    logic [ADDR_W-3:0] word;
    logic              unused_addr_lsb;
    logic              wen;
    int                widx;

    logic [NB-1:0]              we_dir, we_set, we_clr, we_ren, we_fen, we_sts;
    logic [NALT-1:0]            we_alt;
    logic [NB-1:0][BANK_W-1:0]  lvl_w, dir_w, out_w, ren_w, fen_w, sts_w;
    logic [NALT*BANK_W-1:0]     alt_w;

    assign word            = bus_addr[ADDR_W-1:2];
    assign unused_addr_lsb = ^bus_addr[1:0];
    assign wen             = bus_sel & bus_wr;
    assign widx            = int'(word);

    // Write strobe decode, one strobe per mapped word.
    always_comb begin
        we_dir = '0; we_set = '0; we_clr = '0;
        we_ren = '0; we_fen = '0; we_sts = '0;
        we_alt = '0;
        for (int b = 0; b < NB; b++) begin
            if (wen && widx == int'(REG_DIR) * NB + b) we_dir[b] = 1'b1;
            if (wen && widx == int'(REG_SET) * NB + b) we_set[b] = 1'b1;
            if (wen && widx == int'(REG_CLR) * NB + b) we_clr[b] = 1'b1;
            if (wen && widx == int'(REG_REN) * NB + b) we_ren[b] = 1'b1;
            if (wen && widx == int'(REG_FEN) * NB + b) we_fen[b] = 1'b1;
            if (wen && widx == int'(REG_STS) * NB + b) we_sts[b] = 1'b1;
        end
        for (int a = 0; a < NALT; a++) begin
            if (wen && widx == ALT0 + a) we_alt[a] = 1'b1;
        end
    end

    // Combinational read mux; unmapped and write-only words give zero.
    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_wr) begin
            for (int b = 0; b < NB; b++) begin
                if (widx == int'(REG_LVL) * NB + b) bus_rdata = lvl_w[b];
                if (widx == int'(REG_DIR) * NB + b) bus_rdata = dir_w[b];
                if (widx == int'(REG_REN) * NB + b) bus_rdata = ren_w[b];
                if (widx == int'(REG_FEN) * NB + b) bus_rdata = fen_w[b];
                if (widx == int'(REG_STS) * NB + b) bus_rdata = sts_w[b];
            end
            for (int a = 0; a < NALT; a++) begin
                if (widx == ALT0 + a) bus_rdata = alt_w[a*BANK_W +: BANK_W];
            end
        end
    end

    for (genvar b = 0; b < NB; b++) begin : g_bank
        gpb_pin_bank #(.W(BANK_W)) u_bank (
            .clk    (clk),
            .rst_n  (rst_n),
            .pin_in (pin_in[b*BANK_W +: BANK_W]),
            .we_dir (we_dir[b]),
            .we_set (we_set[b]),
            .we_clr (we_clr[b]),
            .we_ren (we_ren[b]),
            .we_fen (we_fen[b]),
            .we_sts (we_sts[b]),
            .wdata  (bus_wdata),
            .level  (lvl_w[b]),
            .dir    (dir_w[b]),
            .dout   (out_w[b]),
            .ren    (ren_w[b]),
            .fen    (fen_w[b]),
            .sts    (sts_w[b])
        );
        assign pin_out[b*BANK_W +: BANK_W] = out_w[b];
        assign pin_oe[b*BANK_W +: BANK_W]  = dir_w[b];
    end

    gpb_alt_store #(.NW(NALT), .W(BANK_W)) u_alt (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (we_alt),
        .wdata (bus_wdata),
        .codes (alt_w)
    );

    assign alt_sel = alt_w;
    assign irq     = |sts_w;

    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && widx >= LAST) |-> (bus_rdata == '0)); // R12
    AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !(|we_sts)) |=> irq); // R10
endmodule

// File: tb/sim_gpb_ctrl.sv
`timescale 1ns/1ps
module sim_gpb_ctrl;
    localparam int  NP  = 96;
    localparam time CLK = 20ns;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_sel = 1'b0, bus_wr = 1'b0;
    logic [7:0]        bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic [NP-1:0]     pin_in = '0;
    logic [NP-1:0]     pin_out, pin_oe;
    logic [2*NP-1:0]   alt_sel;
    logic              irq;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK/2) clk = ~clk;

    gpb_ctrl #(.NPINS(NP), .ADDR_W(8)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
        .alt_sel(alt_sel), .irq(irq)
    );

    // Vector table: write (1) or read-and-compare (0). Map for 3 banks (R1):
    // dir 12.., set 24.., clr 36.., ren 48.., fen 60.., sts 72.., alt 84..104.
    localparam int NV = 13;
    localparam logic        V_WR   [NV] = '{1, 0, 1, 0, 1, 0, 1, 0, 0, 1, 0, 1, 0};
    localparam logic [7:0]  V_ADDR [NV] = '{12, 12, 104, 104, 56, 56, 108, 108, 24, 64, 64, 20, 20};
    localparam logic [31:0] V_DATA [NV] = '{32'hA5A5_0F0F, 32'hA5A5_0F0F, 32'hDEAD_BEEF, 32'hDEAD_BEEF,
                                            32'h8000_0001, 32'h8000_0001, 32'hFFFF_FFFF, 32'h0,
                                            32'h0, 32'h1234_5678, 32'h1234_5678, 32'h0000_C003, 32'h0000_C003};
    localparam string       V_REQ  [NV] = '{"R1", "R5", "R1", "R9", "R1", "R5", "R12", "R12",
                                            "R12", "R1", "R5", "R1", "R5"};

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        #(CLK * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11 reset state
        chk("R11", {31'd0, irq}, 32'd0);
        chk("R11", pin_out[31:0] | pin_out[95:64], 32'd0);
        chk("R11", pin_oe[63:32], 32'd0);
        chk("R11", alt_sel[191:160] | alt_sel[31:0], 32'd0);
        rd(8'd16, d);  chk("R11", d, 32'd0);
        rd(8'd76, d);  chk("R11", d, 32'd0);
        rd(8'd88, d);  chk("R11", d, 32'd0);

        // Table walk
        for (int i = 0; i < NV; i++) begin
            if (V_WR[i]) wr(V_ADDR[i], V_DATA[i]);
            else begin
                rd(V_ADDR[i], d);
                chk(V_REQ[i], d, V_DATA[i]);
            end
        end

        // R5 direction drives output enable
        chk("R5", pin_oe[31:0], 32'hA5A5_0F0F);
        chk("R5", pin_oe[95:64], 32'h0000_C003);
        // R9 codes on alt_sel: word 5 holds pins 80..95; pin 81 at bits [3:2]
        chk("R9", alt_sel[160 +: 32], 32'hDEAD_BEEF);
        chk("R9", {30'd0, alt_sel[2*81 +: 2]}, 32'd3);
        chk("R9", {30'd0, alt_sel[2*0 +: 2]}, 32'd0);

        // R3 / R4 set and clear on bank 1
        wr(8'd28, 32'h0000_00F0);
        chk("R3", pin_out[63:32], 32'h0000_00F0);
        wr(8'd28, 32'h0000_0003);
        chk("R3", pin_out[63:32], 32'h0000_00F3);
        wr(8'd40, 32'h0000_0010);
        chk("R4", pin_out[63:32], 32'h0000_00E3);
        chk("R4", pin_out[31:0], 32'd0);
        rd(8'd40, d); chk("R12", d, 32'd0);

        // Clear all enables and status before pin activity
        for (int a = 48; a <= 68; a += 4) wr(8'(a), 32'd0);
        for (int a = 72; a <= 80; a += 4) wr(8'(a), 32'hFFFF_FFFF);

        // R2 level readback, writes to level ignored
        pin_in = 96'hCAFE_F00D_1234_5678_9ABC_DEF0;
        settle();
        rd(8'd0, d); chk("R2", d, 32'h9ABC_DEF0);
        rd(8'd4, d); chk("R2", d, 32'h1234_5678);
        rd(8'd8, d); chk("R2", d, 32'hCAFE_F00D);
        wr(8'd0, 32'h0);
        rd(8'd0, d); chk("R2", d, 32'h9ABC_DEF0);
        rd(8'd72, d); chk("R6", d, 32'd0);
        pin_in = '0;
        settle();

        // R6 / R7 single-edge enables on bank 0
        wr(8'd48, 32'h0000_0008);
        wr(8'd60, 32'h0000_0020);
        pin_in[3] = 1'b1; pin_in[5] = 1'b1; pin_in[7] = 1'b1;
        settle();
        rd(8'd72, d); chk("R6", d, 32'h0000_0008);
        chk("R10", {31'd0, irq}, 32'd1);
        pin_in[3] = 1'b0; pin_in[5] = 1'b0; pin_in[7] = 1'b0;
        settle();
        rd(8'd72, d); chk("R7", d, 32'h0000_0028);

        // R8 bitwise clear, R10 irq follows
        wr(8'd72, 32'h0000_0008);
        rd(8'd72, d); chk("R8", d, 32'h0000_0020);
        chk("R10", {31'd0, irq}, 32'd1);
        wr(8'd72, 32'hFFFF_FFFF);
        rd(8'd72, d); chk("R8", d, 32'd0);
        chk("R10", {31'd0, irq}, 32'd0);

        // R6 / R7 both enables on pin 95
        wr(8'd56, 32'h8000_0000);
        wr(8'd68, 32'h8000_0000);
        pin_in[95] = 1'b1;
        settle();
        rd(8'd80, d); chk("R6", d, 32'h8000_0000);
        wr(8'd80, 32'h8000_0000);
        rd(8'd80, d); chk("R8", d, 32'd0);
        pin_in[95] = 1'b0;
        settle();
        rd(8'd80, d); chk("R7", d, 32'h8000_0000);
        wr(8'd80, 32'hFFFF_FFFF);

        // R8 collision: pending pin 3, new rise lands in the clearing cycle
        pin_in[3] = 1'b1;
        settle();
        pin_in[3] = 1'b0;
        settle();
        rd(8'd72, d); chk("R8", d, 32'h0000_0008);
        @(negedge clk); pin_in[3] = 1'b1;
        @(negedge clk);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 8'd72; bus_wdata = 32'h0000_0008;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
        rd(8'd72, d); chk("R8", d, 32'h0000_0008);
        chk("R10", {31'd0, irq}, 32'd1);

        // R12 unmapped write leaves registers untouched
        wr(8'd200, 32'hFFFF_FFFF);
        rd(8'd200, d); chk("R12", d, 32'd0);
        rd(8'd12, d);  chk("R12", d, 32'hA5A5_0F0F);
        chk("R12", pin_out[63:32], 32'h0000_00E3);

        finish_run();
    end
endmodule